// File: doc/BRIEF.md
# Glitch-Free Dual Clock Source Selector

This block produces one system clock from two sources: a time base clock that never stops, and an RC oscillator clock that only needs to run while it is in use. A single request input selects the wanted source. Before the block hands the output over to the RC clock, it enables the oscillator and lets it settle for a fixed number of time base cycles. Only then does it move the output across.

Both directions of the handover use a cross-coupled gating scheme. The current source's gate closes on that source's falling edge. The other source's gate opens on its own falling edge, and only after the closed gate has been seen through a synchronizer in its domain. The output therefore never carries a shortened high or low phase.

A status output tells software which source really drives the output. It moves only once a handover has finished, so software can poll it after asking for a change. A request that changes while a handover is under way is held until that handover is done, and is then acted on.

Top module: `clk_src_select`

## Requirements
- R1: After reset, on_tb_o is 1, rc_osc_en_o is 0 and clk_o follows tb_clk_i.
- R2: Setting rc_req_i to 1 raises rc_osc_en_o within a few time base cycles, while on_tb_o stays 1.
- R3: on_tb_o falls no sooner than 128 and no later than 140 rising edges of tb_clk_i after rc_osc_en_o rose.
- R4: Once on_tb_o is 0, clk_o follows rc_clk_i.
- R5: Neither handover direction produces a high or low pulse on clk_o shorter than the shorter half period of the two source clocks.
- R6: on_tb_o reads 1 for the time base and 0 for RC. It changes only after the gate of the new source is open and the gate of the old source is closed.
- R7: If rc_req_i is withdrawn before the settle count completes, rc_osc_en_o drops, on_tb_o never falls, and a later request counts the full 128 cycles again.
- R8: A withdrawal that arrives during the handover to RC is held. The handover completes (on_tb_o falls) and the block then returns to the time base. rc_osc_en_o is 1 whenever on_tb_o is 0.
- R9: After rc_req_i returns to 0 from RC, on_tb_o rises and clk_o follows tb_clk_i again. rc_osc_en_o falls no earlier than on_tb_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tb_clk_i | input | 1 | Always-running time base clock |
| rc_clk_i | input | 1 | RC oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_req_i | input | 1 | Source request: 1 = RC, 0 = time base (asynchronous) |
| clk_o | output | 1 | Glitch-free selected clock |
| rc_osc_en_o | output | 1 | Enable for the RC oscillator |
| on_tb_o | output | 1 | Active source: 1 = time base, 0 = RC |

## Verification
Two events can fall in the same cycle: the withdrawal of the request and the end of the settle count, which starts the handover. The bench sweeps the delay between the oscillator enable and the withdrawal, one time base cycle at a time, across that boundary.

Far below the boundary, the status must never fall. Far above it, the handover must complete before the block returns. Inside the uncertain band, either outcome is accepted, but the block must always end on the time base with the oscillator off.

A pulse-width monitor runs on clk_o throughout the sweep to judge every handover.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  typedef enum logic [2:0] {
    ST_TB    = 3'd0,
    ST_WARM  = 3'd1,
    ST_TO_RC = 3'd2,
    ST_RC    = 3'd3,
    ST_TO_TB = 3'd4
  } src_state_e;
endpackage

// File: rtl/sync_ff.sv
module sync_ff #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clk_gate_mux.sv
module clk_gate_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic tb_clk_i,
  input  logic rc_clk_i,
  input  logic rst_ni,
  input  logic sel_rc_i,
  output logic clk_o,
  output logic tb_live_o,
  output logic rc_live_o
);
  logic tb_gate_q, rc_gate_q;
  logic rc_fb_tb;
  logic [1:0] tb_view_rc;

  // rc gate state seen in tb domain
  sync_ff #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rc_to_tb (
    .clk_i (tb_clk_i),
    .rst_ni(rst_ni),
    .d_i   (rc_gate_q),
    .q_o   (rc_fb_tb)
  );

  // {select, tb gate} seen in rc domain
  sync_ff #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_tb_to_rc (
    .clk_i (rc_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_rc_i, tb_gate_q}),
    .q_o   (tb_view_rc)
  );

  // gates change only while their clock is low
  always_ff @(negedge tb_clk_i or negedge rst_ni) begin
    if (!rst_ni) tb_gate_q <= 1'b1;
    else         tb_gate_q <= !sel_rc_i && !rc_fb_tb;
  end

  always_ff @(negedge rc_clk_i or negedge rst_ni) begin
    if (!rst_ni) rc_gate_q <= 1'b0;
    else         rc_gate_q <= tb_view_rc[1] && !tb_view_rc[0];
  end

  assign clk_o     = (tb_clk_i & tb_gate_q) | (rc_clk_i & rc_gate_q);
  assign tb_live_o = tb_gate_q && !rc_fb_tb;
  assign rc_live_o = rc_fb_tb;

  // R5
  gates_exclusive_chk: assert property (@(posedge tb_clk_i) disable iff (!rst_ni)
    !(tb_gate_q && rc_gate_q));
endmodule

// File: rtl/src_ctrl.sv
module src_ctrl
  import clk_src_pkg::*;
#(
  parameter int SETTLE      = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic tb_clk_i,
  input  logic rst_ni,
  input  logic rc_req_i,
  input  logic tb_live_i,
  input  logic rc_live_i,
  output logic sel_rc_o,
  output logic rc_osc_en_o,
  output logic on_tb_o
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam int WW = $clog2(SETTLE + 2) + 1;

  src_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          req_s;

  sync_ff #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk_i (tb_clk_i),
    .rst_ni(rst_ni),
    .d_i   (rc_req_i),
    .q_o   (req_s)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TB:    if (req_s) state_d = ST_WARM;
      ST_WARM:  if (!req_s) state_d = ST_TB;
                else if (cnt_q == CW'(SETTLE - 1)) state_d = ST_TO_RC;
      ST_TO_RC: if (rc_live_i) state_d = ST_RC;   // request held meanwhile
      ST_RC:    if (!req_s) state_d = ST_TO_TB;
      ST_TO_TB: if (tb_live_i) state_d = ST_TB;
      default:  state_d = ST_TB;
    endcase
  end

  always_ff @(posedge tb_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_TB;
      cnt_q       <= '0;
      sel_rc_o    <= 1'b0;
      rc_osc_en_o <= 1'b0;
      on_tb_o     <= 1'b1;
    end else begin
      state_q     <= state_d;
      cnt_q       <= (state_q == ST_WARM && state_d == ST_WARM) ? cnt_q + 1'b1 : '0;
      sel_rc_o    <= (state_d == ST_TO_RC) || (state_d == ST_RC);
      rc_osc_en_o <= (state_d != ST_TB);
      on_tb_o     <= (state_d == ST_TB) || (state_d == ST_WARM) || (state_d == ST_TO_RC);
    end
  end

  // checker: cycles with oscillator on while still on time base
  logic [WW-1:0] on_cnt_q;
  always_ff @(posedge tb_clk_i or negedge rst_ni) begin
    if (!rst_ni)                      on_cnt_q <= '0;
    else if (!rc_osc_en_o)            on_cnt_q <= '0;
    else if (on_cnt_q != WW'(SETTLE + 1)) on_cnt_q <= on_cnt_q + 1'b1;
  end

  // R3
  settle_window_chk: assert property (@(posedge tb_clk_i) disable iff (!rst_ni)
    $fell(on_tb_o) |-> on_cnt_q >= WW'(SETTLE));
  // R8
  rc_running_chk: assert property (@(posedge tb_clk_i) disable iff (!rst_ni)
    !on_tb_o |-> rc_osc_en_o);
  // R6
  tb_done_chk: assert property (@(posedge tb_clk_i) disable iff (!rst_ni)
    $rose(on_tb_o) |-> tb_live_i);
  // R6
  rc_done_chk: assert property (@(posedge tb_clk_i) disable iff (!rst_ni)
    $fell(on_tb_o) |-> rc_live_i);
endmodule

// File: rtl/clk_src_select.sv
module clk_src_select #(
  parameter int SETTLE      = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic tb_clk_i,
  input  logic rc_clk_i,
  input  logic rst_ni,
  input  logic rc_req_i,
  output logic clk_o,
  output logic rc_osc_en_o,
  output logic on_tb_o
);
  logic sel_rc, tb_live, rc_live;

  src_ctrl #(.SETTLE(SETTLE), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .tb_clk_i   (tb_clk_i),
    .rst_ni     (rst_ni),
    .rc_req_i   (rc_req_i),
    .tb_live_i  (tb_live),
    .rc_live_i  (rc_live),
    .sel_rc_o   (sel_rc),
    .rc_osc_en_o(rc_osc_en_o),
    .on_tb_o    (on_tb_o)
  );

  clk_gate_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .tb_clk_i (tb_clk_i),
    .rc_clk_i (rc_clk_i),
    .rst_ni   (rst_ni),
    .sel_rc_i (sel_rc),
    .clk_o    (clk_o),
    .tb_live_o(tb_live),
    .rc_live_o(rc_live)
  );
endmodule

// File: tb/clk_src_select_test.sv
`timescale 1ns/1ps
module clk_src_select_test;
  logic tb_clk = 1'b0, rc_clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic clk_out, osc_en, on_tb;
  int checks = 0, fails = 0, glitches = 0, en_viol = 0, cyc = 0;
  bit armed = 0;
  realtime last_edge = 0.0;

  clk_src_select uut (
    .tb_clk_i(tb_clk), .rc_clk_i(rc_clk), .rst_ni(rst_n), .rc_req_i(req),
    .clk_o(clk_out), .rc_osc_en_o(osc_en), .on_tb_o(on_tb)
  );

  always #5 tb_clk = ~tb_clk;               // 100 MHz time base
  initial begin #3; forever #7 rc_clk = ~rc_clk; end

  // R5 pulse width monitor (min half period 5 ns)
  always @(clk_out) begin
    if (armed && ($realtime - last_edge) < 4.5) glitches++;
    last_edge = $realtime;
  end
  // R8 continuous
  always @(negedge tb_clk) if (armed && !on_tb && !osc_en) en_viol++;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin @(posedge tb_clk); cyc++;
      if (cyc > 150000) begin fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000); finish_run(); end
    end
  end

  task automatic tick(int n); repeat (n) begin @(posedge tb_clk); #1; end endtask

  task automatic follows_tb(string tag);
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge tb_clk); #2.5; if (clk_out !== 1'b1) bad++;
      @(negedge tb_clk); #2.5; if (clk_out !== 1'b0) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic follows_rc(string tag);
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge rc_clk); #2; if (clk_out !== 1'b1) bad++;
      @(negedge rc_clk); #2; if (clk_out !== 1'b0) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic wait_osc(output int waited);
    waited = 0;
    while (!osc_en && waited < 20) begin tick(1); waited++; end
  endtask

  task automatic settle_back();
    int k = 0;
    while (!(on_tb && !osc_en) && k < 100) begin tick(1); k++; end
    tick(4);
  endtask

  initial begin
    int w, n;
    bit saw_rc;
    tick(5); rst_n = 1'b1; armed = 1; tick(3);

    check(on_tb === 1'b1, "R1 status", on_tb, 1);
    check(osc_en === 1'b0, "R1 osc_en", osc_en, 0);
    follows_tb("R1 clk follows tb");

    // full switch to RC
    req = 1'b1;
    wait_osc(w);
    check(osc_en === 1'b1 && w <= 5, "R2 osc_en rise", w, 3);
    check(on_tb === 1'b1, "R2 status held", on_tb, 1);
    n = 0;
    while (on_tb && n < 300) begin tick(1); n++; end
    check(n >= 128 && n <= 140, "R3 settle cycles", n, 128);
    check(on_tb === 1'b0, "R6 status rc", on_tb, 0);
    follows_rc("R4 clk follows rc");

    // back to time base
    req = 1'b0;
    n = 0;
    while (!on_tb && n < 50) begin
      tick(1); n++;
      if (!on_tb && !osc_en) en_viol++;
    end
    check(on_tb === 1'b1, "R9 status tb", on_tb, 1);
    settle_back();
    check(osc_en === 1'b0, "R9 osc off", osc_en, 0);
    follows_tb("R9 clk follows tb");

    // R7 abort then restart full count
    req = 1'b1; wait_osc(w); tick(100);
    req = 1'b0; settle_back();
    check(on_tb === 1'b1 && osc_en === 1'b0, "R7 abort", {on_tb, osc_en}, 2);
    req = 1'b1; wait_osc(w);
    n = 0;
    while (on_tb && n < 300) begin tick(1); n++; end
    check(n >= 128 && n <= 140, "R7 restart count", n, 128);
    req = 1'b0; settle_back();

    // sweep withdrawal delay across settle end
    for (int d = 0; d <= 145; d++) begin
      saw_rc = 0;
      req = 1'b1; wait_osc(w);
      for (int k = 0; k < d; k++) begin tick(1); if (!on_tb) saw_rc = 1; end
      req = 1'b0;
      for (int k = 0; k < 60; k++) begin tick(1); if (!on_tb) saw_rc = 1; end
      settle_back();
      if (d < 120) check(!saw_rc, $sformatf("R7 d=%0d no handover", d), saw_rc, 0);
      if (d >= 131) check(saw_rc, $sformatf("R8 d=%0d held handover", d), saw_rc, 1);
      check(on_tb === 1'b1 && osc_en === 1'b0, $sformatf("R9 d=%0d end state", d),
            {on_tb, osc_en}, 2);
    end
    follows_tb("R9 clk after sweep");

    check(glitches == 0, "R5 no short pulses", glitches, 0);
    check(en_viol == 0, "R8 osc on while rc", en_viol, 0);
    finish_run();
  end
endmodule